// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel of a multi-channel event timer. It receives the shared free-running main counter and the block-wide enable. It holds a configuration word, a comparator and a hidden period register, and it raises an interrupt when the counter reaches the comparator. A register decoder outside the block presents writes as 32-bit halves through a two-bit half selector. The channel reports its configuration and comparator back for reads.

The channel runs one-shot or periodic. It compares either all 64 bits or only the low 32 bits of the counter, and it signals either as a one-clock pulse or as a held level with a status bit. In periodic mode, comparator writes normally load the hidden period. A self-clearing set-value bit lets software place the first expiry time and the period with a single write. In 32-bit one-shot mode, a target that lies beyond the next 32-bit counter wrap produces an extra expiry when the low half rolls over. The true match follows later.

Write half selector codes: 0 = configuration low word, 1 = configuration high word (read-only), 2 = comparator/period low half, 3 = comparator/period high half. Configuration low-word fields:

| Bit | Field |
|---|---|
| 1 | level type (1) / edge type (0) |
| 2 | channel enable |
| 3 | periodic mode |
| 4 | periodic capable (read-only, 1) |
| 5 | 64-bit capable (read-only, 1) |
| 6 | set-value |
| 8 | 32-bit mode |
| 13:9 | output line select |

All other bits are read-only zero.

Top module: `evt_chan_top`

## Requirements
- R1: After reset, `cfg_o` reads 64'h0000_0004_0000_0030, `cmp_o` reads all ones, `status_o` is 0 and no interrupt line is high.
- R2: A configuration low-word write changes only bits 1, 2, 3, 6, 8 and 13:9. The capability bits 5:4 stay 1. A write to the configuration high word changes nothing, and that word always reads 32'h4.
- R3: When the channel enable (bit 2) and `global_en_i` are both 1 and the counter equals the comparator in the sampled cycle, the interrupt appears on the selected line one clock later. The comparison uses the full 64 bits in 64-bit mode.
- R4: Edge type: an expiry drives the selected line high for exactly one clock and leaves `status_o` at 0.
- R5: Level type: an expiry sets `status_o` and holds the selected line high. Either enable going to 0 clears both, one clock after the cleared enable is seen.
- R6: At most one line is high, and it is the line whose index equals configuration bits 13:9.
- R7: In one-shot mode, or in periodic mode with set-value (bit 6) at 1, a comparator write loads the written comparator half. In periodic mode it also loads the same half of the period. Otherwise it loads only the period. Any comparator write clears bit 6.
- R8: The period's top bit is forced to 0 on load: bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R9: On a comparator match in periodic mode with a non-zero period, the comparator advances by the period, modulo 2^32 in 32-bit mode, so the next expiry comes exactly one period later.
- R10: A configuration write with bit 8 at 1 clears the upper halves of the comparator and the period. In 32-bit mode, high-half comparator writes are ignored and only the low 32 bits of the counter are compared.
- R11: In 32-bit one-shot mode, if the comparator's low half is below the counter's low half when the channel is armed, the channel expires once when the counter's low half is all ones. It expires again at the true match. Arming happens on enable rising, on global enable rising, or on a comparator write while globally enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Shared main counter value |
| global_en_i | input | 1 | Block-wide enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Half selector (0 cfg lo, 1 cfg hi, 2 cmp lo, 3 cmp hi) |
| wr_data_i | input | 32 | Write data |
| cfg_o | output | 64 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| status_o | output | 1 | Level-type interrupt status |
| irq_lines_o | output | N_LINES | Routed interrupt lines |

## Verification
The comparator is tried in four settings, and each isolates a different branch of the update rules:
- 64-bit one-shot on a low counter value, which separates a full-width match from a truncated one.
- 64-bit periodic, where the spacing of successive pulses tells a period reload from a comparator reload.
- 32-bit periodic on a counter with non-zero upper bits, which shows that the high half is neither compared nor written.
- 32-bit one-shot started just below a 32-bit wrap, where the counter values at the two expiries tell the wrap pulse from the true match.

Large period writes show whether the top bit is forced to zero. Edge and level types are both tried, and level status is cleared by each of the two enables in turn.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
   localparam int HALF_W   = 32;
   localparam int CNT_W    = 2 * HALF_W;
   localparam int ROUTE_FW = 5;

   typedef enum logic [1:0] {
      SEL_CFG_LO = 2'd0,
      SEL_CFG_HI = 2'd1,
      SEL_CMP_LO = 2'd2,
      SEL_CMP_HI = 2'd3
   } half_sel_e;

   localparam int B_LEVEL    = 1;
   localparam int B_ENABLE   = 2;
   localparam int B_PERIODIC = 3;
   localparam int B_PER_CAP  = 4;
   localparam int B_SIZE_CAP = 5;
   localparam int B_SETVAL   = 6;
   localparam int B_MODE32   = 8;
   localparam int B_ROUTE_LO = 9;

   localparam logic [HALF_W-1:0] CFG_WMASK = 32'h0000_3F4E;
   localparam logic [HALF_W-1:0] CFG_RESET =
      (HALF_W'(1) << B_PER_CAP) | (HALF_W'(1) << B_SIZE_CAP);
endpackage

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
   import evt_chan_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [HALF_W-1:0] wr_data_i,
   input  logic              reload_i,
   output logic [HALF_W-1:0] cfg_q_o,
   output logic [HALF_W-1:0] cfg_n_o,
   output logic [CNT_W-1:0]  cmp_q_o,
   output logic [CNT_W-1:0]  cmp_n_o,
   output logic [CNT_W-1:0]  per_q_o
);
   logic [HALF_W-1:0] cfg_q, cfg_n;
   logic [CNT_W-1:0]  cmp_q, cmp_n, per_q, per_n;
   logic              m32, per_mode, setval, cmp_wr_ok;
   half_sel_e         sel;

   assign sel       = half_sel_e'(wr_sel_i);
   assign m32       = cfg_q[B_MODE32];
   assign per_mode  = cfg_q[B_PERIODIC];
   assign setval    = cfg_q[B_SETVAL];
   assign cmp_wr_ok = !per_mode || setval;

   always_comb begin
      cfg_n = cfg_q;
      cmp_n = cmp_q;
      per_n = per_q;
      if (reload_i) begin
         if (m32) cmp_n = {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0]};
         else     cmp_n = cmp_q + per_q;
      end
      if (wr_en_i) begin
         unique case (sel)
            SEL_CFG_LO: begin
               cfg_n = (cfg_q & ~CFG_WMASK) | (wr_data_i & CFG_WMASK);
               if (wr_data_i[B_MODE32]) begin
                  cmp_n = {{HALF_W{1'b0}}, cmp_n[HALF_W-1:0]};
                  per_n = {{HALF_W{1'b0}}, per_q[HALF_W-1:0]};
               end
            end
            SEL_CMP_LO: begin
               if (cmp_wr_ok) cmp_n[HALF_W-1:0] = wr_data_i;
               if (per_mode)
                  per_n[HALF_W-1:0] = m32 ? {1'b0, wr_data_i[HALF_W-2:0]} : wr_data_i;
               cfg_n[B_SETVAL] = 1'b0;
            end
            SEL_CMP_HI: begin
               if (!m32) begin
                  if (cmp_wr_ok) cmp_n[CNT_W-1:HALF_W] = wr_data_i;
                  if (per_mode)  per_n[CNT_W-1:HALF_W] = {1'b0, wr_data_i[HALF_W-2:0]};
               end
               cfg_n[B_SETVAL] = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= CFG_RESET;
         cmp_q <= '1;
         per_q <= '0;
      end else begin
         cfg_q <= cfg_n;
         cmp_q <= cmp_n;
         per_q <= per_n;
      end
   end

   assign cfg_q_o = cfg_q;
   assign cfg_n_o = cfg_n;
   assign cmp_q_o = cmp_q;
   assign cmp_n_o = cmp_n;
   assign per_q_o = per_q;
endmodule

// File: rtl/evt_chan_match.sv
module evt_chan_match
   import evt_chan_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  cmp_i,
   input  logic              mode32_i,
   input  logic              periodic_i,
   input  logic              per_nz_i,
   input  logic              en_all_i,
   input  logic              arm_i,
   input  logic [HALF_W-1:0] arm_cmp_i,
   input  logic              arm_mode32_i,
   input  logic              arm_periodic_i,
   output logic              fire_o,
   output logic              reload_o
);
   logic wrap_q, match, wrap_hit, arm_cond;

   assign match    = mode32_i ? (cnt_i[HALF_W-1:0] == cmp_i[HALF_W-1:0])
                              : (cnt_i == cmp_i);
   assign wrap_hit = wrap_q && mode32_i && !periodic_i && (&cnt_i[HALF_W-1:0]);
   assign arm_cond = arm_mode32_i && !arm_periodic_i &&
                     (arm_cmp_i < cnt_i[HALF_W-1:0]);
   assign fire_o   = en_all_i && (match || wrap_hit);
   assign reload_o = en_all_i && match && periodic_i && per_nz_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  wrap_q <= 1'b0;
      else if (arm_i)               wrap_q <= arm_cond;
      else if (en_all_i && wrap_hit) wrap_q <= 1'b0;
   end
endmodule

// File: rtl/evt_chan_irq.sv
module evt_chan_irq
   import evt_chan_pkg::*;
#(
   parameter int N_LINES = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                en_all_i,
   input  logic                fire_i,
   input  logic                level_i,
   input  logic [ROUTE_FW-1:0] route_i,
   output logic                status_o,
   output logic [N_LINES-1:0]  lines_o
);
   logic status_q, irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= en_all_i && (fire_i ? level_i : status_q);
         irq_q    <= en_all_i && (fire_i || (level_i && status_q));
      end
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign lines_o[i] = irq_q && (route_i == ROUTE_FW'(i));
   end

   assign status_o = status_q;
endmodule

// File: rtl/evt_chan_top.sv
module evt_chan_top
   import evt_chan_pkg::*;
#(
   parameter int                N_LINES   = 32,
   parameter logic [HALF_W-1:0] ROUTE_CAP = 32'h0000_0004
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic               global_en_i,
   input  logic               wr_en_i,
   input  logic [1:0]         wr_sel_i,
   input  logic [HALF_W-1:0]  wr_data_i,
   output logic [CNT_W-1:0]   cfg_o,
   output logic [CNT_W-1:0]   cmp_o,
   output logic               status_o,
   output logic [N_LINES-1:0] irq_lines_o
);
   if (N_LINES < 1 || N_LINES > (1 << ROUTE_FW)) begin : g_bad_lines
      $error("evt_chan_top: N_LINES must lie in 1..32");
   end

   logic [HALF_W-1:0] cfg_q, cfg_n;
   logic [CNT_W-1:0]  cmp_q, cmp_n, per_q;
   logic gen_q, en_all, en_rise, cmp_wr, arm, fire, reload;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gen_q <= 1'b0;
      else         gen_q <= global_en_i;
   end

   assign en_all  = cfg_q[B_ENABLE] && global_en_i;
   assign en_rise = wr_en_i && (wr_sel_i == SEL_CFG_LO) &&
                    wr_data_i[B_ENABLE] && !cfg_q[B_ENABLE];
   assign cmp_wr  = wr_en_i && global_en_i &&
                    ((wr_sel_i == SEL_CMP_LO) || (wr_sel_i == SEL_CMP_HI));
   assign arm     = en_rise || cmp_wr || (global_en_i && !gen_q);

   evt_chan_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .reload_i  (reload),
      .cfg_q_o   (cfg_q),
      .cfg_n_o   (cfg_n),
      .cmp_q_o   (cmp_q),
      .cmp_n_o   (cmp_n),
      .per_q_o   (per_q)
   );

   evt_chan_match u_match (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cnt_i          (cnt_i),
      .cmp_i          (cmp_q),
      .mode32_i       (cfg_q[B_MODE32]),
      .periodic_i     (cfg_q[B_PERIODIC]),
      .per_nz_i       (|per_q),
      .en_all_i       (en_all),
      .arm_i          (arm),
      .arm_cmp_i      (cmp_n[HALF_W-1:0]),
      .arm_mode32_i   (cfg_n[B_MODE32]),
      .arm_periodic_i (cfg_n[B_PERIODIC]),
      .fire_o         (fire),
      .reload_o       (reload)
   );

   evt_chan_irq #(.N_LINES(N_LINES)) u_irq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_all_i (en_all),
      .fire_i   (fire),
      .level_i  (cfg_q[B_LEVEL]),
      .route_i  (cfg_q[B_ROUTE_LO +: ROUTE_FW]),
      .status_o (status_o),
      .lines_o  (irq_lines_o)
   );

   assign cfg_o = {ROUTE_CAP, cfg_q};
   assign cmp_o = cmp_q;
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk
   import evt_chan_pkg::*;
#(
   parameter int N_LINES = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               global_en_i,
   input logic               wr_en_i,
   input logic [1:0]         wr_sel_i,
   input logic [CNT_W-1:0]   cfg_o,
   input logic [HALF_W-1:0]  cmp_hi,
   input logic               status_o,
   input logic [N_LINES-1:0] irq_lines_o
);
   // R2: a high configuration word write leaves the readback unchanged
   assert_cfg_hi_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i == SEL_CFG_HI) |=> $stable(cfg_o));

   // R3: a line can only be high if both enables were set a cycle earlier
   assert_line_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|irq_lines_o) |-> $past(cfg_o[B_ENABLE] && global_en_i));

   // R4: status only rises after a level-type expiry
   assert_status_only_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o) |-> $past(cfg_o[B_LEVEL]));

   // R5: status holds while level type and both enables stay set
   assert_level_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o && cfg_o[B_LEVEL] && cfg_o[B_ENABLE] && global_en_i) |=> status_o);

   // R5: a missing enable clears status in the next cycle
   assert_en_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg_o[B_ENABLE] && global_en_i) |=> !status_o);

   // R6: never more than one line
   assert_one_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(irq_lines_o));

   // R7: any comparator write leaves set-value clear
   assert_setval_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_sel_i == SEL_CMP_LO || wr_sel_i == SEL_CMP_HI)) |=> !cfg_o[B_SETVAL]);

   // R10: 32-bit mode keeps the comparator's upper half at zero
   assert_mode32_trunc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[B_MODE32] |-> (cmp_hi == '0));
endmodule

bind evt_chan_top evt_chan_chk #(.N_LINES(N_LINES)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .global_en_i (global_en_i),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .cfg_o       (cfg_o),
   .cmp_hi      (cmp_o[63:32]),
   .status_o    (status_o),
   .irq_lines_o (irq_lines_o)
);

// File: tb/tb_evt_chan_top.sv
`timescale 1ns/1ps
module tb_evt_chan_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [63:0] cnt_i;
   logic        global_en_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = 2'd0;
   logic [31:0] wr_data_i = 32'd0;
   logic [63:0] cfg_o, cmp_o;
   logic        status_o;
   logic [31:0] irq_lines_o;

   logic [63:0] ctr = 64'd0;
   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   assign cnt_i = ctr;

   always #5 clk_i = ~clk_i;

   evt_chan_top dut (.*);

   // behavioural reference state
   logic [31:0] m_cfg;
   logic [63:0] m_cmp, m_per;
   logic        m_stat, m_irq, m_wrap, m_gprev;

   always @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         m_cfg = 32'h30; m_cmp = '1; m_per = '0;
         m_stat = 0; m_irq = 0; m_wrap = 0; m_gprev = 0;
      end else begin
         logic [31:0] c, nc;
         logic [63:0] k, p;
         logic on, narrow, rep, hit, wraphit, fire, arm;
         c = m_cfg; k = m_cmp; p = m_per; nc = c;
         on = c[2] && global_en_i;
         narrow = c[8]; rep = c[3];
         hit = narrow ? (cnt_i[31:0] == k[31:0]) : (cnt_i == k);
         wraphit = m_wrap && narrow && !rep && (cnt_i[31:0] == 32'hFFFF_FFFF);
         fire = on && (hit || wraphit);
         m_irq  = on && (fire || (c[1] && m_stat));
         m_stat = !on ? 1'b0 : (fire ? c[1] : m_stat);
         if (fire && hit && rep && p != 0)
            k = narrow ? ((k + p) & 64'hFFFF_FFFF) : (k + p);
         arm = global_en_i && !m_gprev;
         if (wr_en_i) begin
            if (wr_sel_i == 2'd0) begin
               nc = (c & ~32'h3F4E) | (wr_data_i & 32'h3F4E);
               if (wr_data_i[2] && !c[2]) arm = 1;
               if (wr_data_i[8]) begin k = k & 64'hFFFF_FFFF; p = p & 64'hFFFF_FFFF; end
            end else if (wr_sel_i == 2'd2) begin
               if (!rep || c[6]) k[31:0] = wr_data_i;
               if (rep) p[31:0] = narrow ? (wr_data_i & 32'h7FFF_FFFF) : wr_data_i;
               nc[6] = 0;
               if (global_en_i) arm = 1;
            end else if (wr_sel_i == 2'd3) begin
               if (!narrow && (!rep || c[6])) k[63:32] = wr_data_i;
               if (!narrow && rep) p[63:32] = wr_data_i & 32'h7FFF_FFFF;
               nc[6] = 0;
               if (global_en_i) arm = 1;
            end
         end
         if (arm) m_wrap = nc[8] && !nc[3] && (k[31:0] < cnt_i[31:0]);
         else if (on && wraphit) m_wrap = 0;
         m_cfg = nc; m_cmp = k; m_per = p; m_gprev = global_en_i;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      logic [31:0] exp_lines;
      @(posedge clk_i);
      #1;
      exp_lines = m_irq ? (32'h1 << m_cfg[13:9]) : 32'h0;
      checks++;
      if (cfg_o !== {32'h4, m_cfg} || cmp_o !== m_cmp || status_o !== m_stat ||
          irq_lines_o !== exp_lines) begin
         fails++;
         $display("FAIL %s model: act cfg=%h cmp=%h st=%b ln=%h exp cfg=%h cmp=%h st=%b ln=%h",
                  cur_req, cfg_o, cmp_o, status_o, irq_lines_o,
                  {32'h4, m_cfg}, m_cmp, m_stat, exp_lines);
      end
      if (global_en_i) ctr++;
      wr_en_i = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
      tick();
   endtask

   task automatic wait_fire(input int lim);
      for (int i = 0; i < lim; i++) begin
         tick();
         if (irq_lines_o != 0 || status_o) break;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_ni = 1'b1;
      tick();
      cur_req = "R1";
      chk("R1 cfg", cfg_o, 64'h0000_0004_0000_0030);
      chk("R1 cmp", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R1 status", {63'd0, status_o}, 64'd0);
      chk("R1 lines", {32'd0, irq_lines_o}, 64'd0);

      cur_req = "R2";
      wr(2'd0, 32'hFFFF_FFFF);
      chk("R2 mask", cfg_o, 64'h0000_0004_0000_3F7E);
      chk("R10 trunc", cmp_o, 64'h0000_0000_FFFF_FFFF);
      wr(2'd1, 32'h1234_5678);
      chk("R2 hi ro", cfg_o, 64'h0000_0004_0000_3F7E);
      wr(2'd0, 32'h0);
      chk("R2 clear", cfg_o, 64'h0000_0004_0000_0030);

      // 64-bit one-shot edge on line 5
      cur_req = "R3";
      ctr = 64'd1000;
      wr(2'd0, 32'h0000_0A04);
      wr(2'd2, 32'd1010);
      wr(2'd3, 32'd0);
      global_en_i = 1'b1;
      repeat (10) tick();
      chk("R3 early", {32'd0, irq_lines_o}, 64'd0);
      tick();
      chk("R3 R6 line5", {32'd0, irq_lines_o}, 64'h20);
      chk("R4 no status", {63'd0, status_o}, 64'd0);
      cur_req = "R4";
      tick();
      chk("R4 one clock", {32'd0, irq_lines_o}, 64'd0);

      // level type on line 7
      cur_req = "R5";
      wr(2'd0, 32'h0000_0E06);
      wr(2'd2, ctr[31:0] + 32'd6);
      wait_fire(30);
      chk("R5 status", {63'd0, status_o}, 64'd1);
      chk("R5 R6 line7", {32'd0, irq_lines_o}, 64'h80);
      repeat (5) tick();
      chk("R5 held", {32'd0, irq_lines_o}, 64'h80);
      wr(2'd0, 32'h0000_0E02);
      tick();
      chk("R5 chan clear", {31'd0, status_o, irq_lines_o}, 64'd0);
      wr(2'd0, 32'h0000_0E06);
      wr(2'd2, ctr[31:0] + 32'd5);
      wait_fire(30);
      chk("R5 again", {63'd0, status_o}, 64'd1);
      global_en_i = 1'b0;
      tick();
      chk("R5 global clear", {31'd0, status_o, irq_lines_o}, 64'd0);

      // 64-bit periodic on line 3
      cur_req = "R7";
      ctr = 64'd2000;
      wr(2'd0, 32'h0000_064C);
      wr(2'd2, 32'd2010);
      chk("R7 setval load", cmp_o, 64'd2010);
      chk("R7 setval clr", {63'd0, cfg_o[6]}, 64'd0);
      wr(2'd2, 32'd7);
      chk("R7 period only", cmp_o, 64'd2010);
      wr(2'd3, 32'd0);
      global_en_i = 1'b1;
      cur_req = "R9";
      wait_fire(30);
      chk("R9 reload", cmp_o, 64'd2017);
      chk("R9 line3", {32'd0, irq_lines_o}, 64'h8);
      for (int i = 0; i < 6; i++) begin
         tick();
         chk("R9 gap", {32'd0, irq_lines_o}, 64'd0);
      end
      tick();
      chk("R9 next", {32'd0, irq_lines_o}, 64'h8);
      chk("R9 reload2", cmp_o, 64'd2024);

      // 64-bit period top bit
      cur_req = "R8";
      global_en_i = 1'b0;
      ctr = 64'd100;
      wr(2'd0, 32'h0000_004C);
      wr(2'd2, 32'd110);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R7 hi not cmp", cmp_o, 64'd110);
      global_en_i = 1'b1;
      wait_fire(30);
      chk("R8 bit63", cmp_o, 64'h7FFF_FFFF_0000_00DC);

      // 32-bit periodic
      cur_req = "R10";
      global_en_i = 1'b0;
      wr(2'd0, 32'h0000_014C);
      chk("R10 trunc cmp", cmp_o, 64'h0000_0000_0000_00DC);
      ctr = 64'h0000_0003_0000_0100;
      wr(2'd2, 32'h0000_0110);
      wr(2'd2, 32'hFFFF_FFF0);
      wr(2'd3, 32'h0000_ABCD);
      chk("R10 hi ignored", cmp_o, 64'h0000_0000_0000_0110);
      global_en_i = 1'b1;
      wait_fire(40);
      chk("R10 low compare", {32'd0, irq_lines_o}, 64'h1);
      chk("R8 bit31 R9 mod", cmp_o, 64'h0000_0000_8000_0100);

      // 32-bit one-shot across wrap, line 9
      cur_req = "R11";
      global_en_i = 1'b0;
      wr(2'd0, 32'h0000_1304);
      ctr = 64'h0000_0001_FFFF_FFF0;
      wr(2'd2, 32'd5);
      global_en_i = 1'b1;
      wait_fire(40);
      chk("R11 wrap fire", ctr, 64'h0000_0002_0000_0000);
      chk("R11 line9", {32'd0, irq_lines_o}, 64'h200);
      wait_fire(40);
      chk("R11 true match", ctr, 64'h0000_0002_0000_0006);
      tick();
      chk("R11 quiet", {32'd0, irq_lines_o}, 64'd0);

      summary();
      $finish;
   end
endmodule